// File: doc/BRIEF.md
# Coalescing Store Queue with Peer Forwarding

This block sits between one processor's store path and a shared memory arbiter. Store-word writes go into a small queue, so the processor keeps running while memory is slow. The queue writes its entries to memory one at a time, oldest first, and only starts a write when the arbiter reports it is free. If a store hits an address that is already waiting in the queue, it overwrites that entry instead of adding a second one.

Loads check the queue before they go to memory. A two-word load drives two lookup ports, one for each word. A second processor can also look up an address and gets hit and data in the same cycle. When that second processor stores to an address, any copy of that address held here is killed, so an older value never reaches memory after a newer one.

An entry counts as pending while it waits in the queue. While an entry is being written to memory it is in flight. Loads and coalescing see only pending entries. The memory write of an in-flight entry is already ordered by the arbiter.

Top module: `store_queue`

## Requirements
- R1: After synchronous active-low reset the queue is empty: `mem_req`, `st_stall` and all three lookup hit outputs are 0.
- R2: A store offered while the queue holds fewer than DEPTH entries is accepted at the next clock edge with `st_stall` low.
- R3: `mem_req` rises only in the cycle after `arb_idle` was sampled high with a live entry at the head. It then stays high, with `mem_addr` and `mem_data` unchanged, until `mem_done` is sampled.
- R4: Live entries are written to memory in the order their addresses first entered the queue.
- R5: A store to an address with no pending entry, offered while the queue holds DEPTH entries, sees `st_stall` high. The stall lasts until one memory write has completed. The store is accepted at the first edge where `st_stall` is low.
- R6: A store to an address that already has a pending entry replaces that entry's data, even when the queue is full, and never stalls. That address is later written to memory once, with the newest data.
- R7: The two local lookup ports (`ld_addr_lo`, `ld_addr_hi`) each report hit and data combinationally, independent of each other, for pending entries only. A store becomes visible from the cycle after the edge that accepts it.
- R8: The peer lookup port reports hit and data for pending entries in the same cycle that `peer_addr` is applied.
- R9: A peer store (`peer_st_valid`) to the address of a pending entry kills that entry. Lookups miss on it from the next cycle on, and it is dropped from the queue without any memory request.
- R10: An in-flight entry is invisible to lookups and coalescing. If it is killed by a peer store, its memory write still completes, and it is then removed without a retry. A later local store to the same address makes a new entry.
- R11: When a local store and a peer store to the same address happen in the same cycle, the local store wins: the entry holds the local data and stays live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Local store offered this cycle |
| st_addr | input | ADDR_W | Local store word address |
| st_data | input | DATA_W | Local store data |
| st_stall | output | 1 | Store cannot be taken; processor must hold it |
| ld_addr_lo | input | ADDR_W | Local lookup address, first word of a load |
| ld_hit_lo | output | 1 | First-word lookup found a pending entry |
| ld_data_lo | output | DATA_W | First-word forwarded data |
| ld_addr_hi | input | ADDR_W | Local lookup address, second word of a load |
| ld_hit_hi | output | 1 | Second-word lookup found a pending entry |
| ld_data_hi | output | DATA_W | Second-word forwarded data |
| peer_addr | input | ADDR_W | Lookup address from the other processor |
| peer_hit | output | 1 | Peer lookup found a pending entry |
| peer_data | output | DATA_W | Data returned to the peer |
| peer_st_valid | input | 1 | Other processor is storing this cycle |
| peer_st_addr | input | ADDR_W | Address of the peer store |
| arb_idle | input | 1 | Arbiter is free to accept a request |
| mem_req | output | 1 | Memory write request held until done |
| mem_addr | output | ADDR_W | Address of the write in flight |
| mem_data | output | DATA_W | Data of the write in flight |
| mem_done | input | 1 | Memory write completes at this edge |

## Verification
The lookup ports are swept over every address in a 16-word window. The sweeps run at several fill levels: empty, full, after coalescing, after a peer kill and after a full drain. This separates a missed hit from a wrong data word, and the low port from the high and peer ports. Draining is tried four ways: with the arbiter busy, with a full queue and an extra store waiting, with a dead entry in the middle, and with a killed in-flight entry. The memory write log then shows whether order, coalescing, skipping and no-retry behave correctly. Simultaneous local and peer stores, to an address that is held and to one that is not, check that the local store takes priority.

// File: rtl/sq_pkg.sv
// Package sq_pkg: shared types for the store queue.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package sq_pkg;
    // State of the single outstanding memory write.
    typedef enum logic [0:0] {
        DR_IDLE = 1'b0,
        DR_BUSY = 1'b1
    } drain_state_t;
endpackage

// File: rtl/sq_lookup.sv
// Module sq_lookup: compares one key against every slot under a mask and
// returns the one-hot match vector, a hit flag and the selected data.
// Assumes: when UNIQUE is set, the caller guarantees that at most one
// masked slot holds any address, so an OR-mux selects correctly.
module sq_lookup #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter bit UNIQUE = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [DEPTH-1:0][ADDR_W-1:0]  slot_addr,
    input  logic [DEPTH-1:0][DATA_W-1:0]  slot_data,
    input  logic [DEPTH-1:0]              slot_mask,
    input  logic [ADDR_W-1:0]             key,
    output logic [DEPTH-1:0]              match,
    output logic                          hit,
    output logic [DATA_W-1:0]             data
);
    // One comparator per slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = slot_mask[g] && (slot_addr[g] == key);
    end

    assign hit = |match;

    // OR-mux of the matching slot data.
    always_comb begin
        data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            data = data | (slot_data[i] & {DATA_W{match[i]}});
        end
    end

    if (UNIQUE) begin : g_uniq
        // Coalescing keeps pending addresses distinct (R6).
        assert_single_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(match));
    end
endmodule

// File: rtl/sq_drain.sv
// Module sq_drain: sequences writes of the head entry to memory.
// Starts a write when the head is live and the arbiter is idle, holds it
// until done, and pops the head afterwards. A dead head (killed while
// pending) is popped without a request.
// Assumes have_entry stays high while a write is outstanding.
module sq_drain
    import sq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arb_idle,
    input  logic have_entry,
    input  logic head_live,
    input  logic mem_done,
    output logic busy,
    output logic pop
);
    drain_state_t state_q, state_d;

    // Next-state and pop decision.
    always_comb begin
        state_d = state_q;
        pop     = 1'b0;
        case (state_q)
            DR_IDLE: begin
                if (have_entry && !head_live) begin
                    pop = 1'b1;
                end else if (have_entry && arb_idle) begin
                    state_d = DR_BUSY;
                end
            end
            DR_BUSY: begin
                if (mem_done) begin
                    pop     = 1'b1;
                    state_d = DR_IDLE;
                end
            end
            default: state_d = DR_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DR_IDLE;
        else        state_q <= state_d;
    end

    assign busy = (state_q == DR_BUSY);

    // A request only starts after the arbiter reported idle (R3).
    assert_req_after_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(arb_idle));
    // An outstanding write always has an entry behind it (R10).
    assert_busy_has_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> have_entry);
endmodule

// File: rtl/store_queue.sv
// Module store_queue: coalescing store queue with local and peer forwarding
// and peer-store invalidation, draining to a shared memory arbiter.
// Assumes: DEPTH is a power of two (pointers wrap naturally); lookups see
// registered state only; the arbiter orders memory reads behind an
// in-flight write, so in-flight entries need not forward.
module store_queue #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    output logic              st_stall,
    input  logic [ADDR_W-1:0] ld_addr_lo,
    output logic              ld_hit_lo,
    output logic [DATA_W-1:0] ld_data_lo,
    input  logic [ADDR_W-1:0] ld_addr_hi,
    output logic              ld_hit_hi,
    output logic [DATA_W-1:0] ld_data_hi,
    input  logic [ADDR_W-1:0] peer_addr,
    output logic              peer_hit,
    output logic [DATA_W-1:0] peer_data,
    input  logic              peer_st_valid,
    input  logic [ADDR_W-1:0] peer_st_addr,
    input  logic              arb_idle,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    input  logic              mem_done
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = PTR_W + 1;
    localparam int N_LD  = 2;

    logic [DEPTH-1:0][ADDR_W-1:0] slot_addr;
    logic [DEPTH-1:0][DATA_W-1:0] slot_data;
    logic [DEPTH-1:0]             live;
    logic [PTR_W-1:0]             head, tail;
    logic [CNT_W-1:0]             count;

    logic [DEPTH-1:0] inflight, pending;
    logic             busy, pop, push, coalesce, full, have_entry;

    logic [DEPTH-1:0] st_match, kill_match;
    logic             st_hit, kill_hit;
    logic [DATA_W-1:0] st_unused, kill_unused;

    logic [N_LD-1:0][ADDR_W-1:0] ld_key;
    logic [N_LD-1:0]             ld_hit;
    logic [N_LD-1:0][DATA_W-1:0] ld_data;
    logic [N_LD-1:0][DEPTH-1:0]  ld_match;
    logic [DEPTH-1:0]            peer_match;

    assign have_entry = (count != '0);
    assign full       = (count == CNT_W'(DEPTH));
    assign inflight   = busy ? (DEPTH'(1) << head) : '0;
    assign pending    = live & ~inflight;

    // Store path: coalesce into a pending match, else push, else stall.
    assign coalesce = st_valid && st_hit;
    assign push     = st_valid && !st_hit && !full;
    assign st_stall = st_valid && !st_hit && full;

    sq_lookup #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .UNIQUE(1'b1)) u_st_cmp (
        .clk(clk), .rst_n(rst_n), .slot_addr(slot_addr), .slot_data(slot_data),
        .slot_mask(pending), .key(st_addr), .match(st_match), .hit(st_hit), .data(st_unused));

    // Peer stores kill every live copy, in flight or not.
    sq_lookup #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .UNIQUE(1'b0)) u_kill_cmp (
        .clk(clk), .rst_n(rst_n), .slot_addr(slot_addr), .slot_data(slot_data),
        .slot_mask(live), .key(peer_st_addr), .match(kill_match), .hit(kill_hit),
        .data(kill_unused));

    assign ld_key[0] = ld_addr_lo;
    assign ld_key[1] = ld_addr_hi;

    // One lookup per word of a local load.
    for (genvar w = 0; w < N_LD; w++) begin : g_ld
        sq_lookup #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .UNIQUE(1'b1)) u_ld_cmp (
            .clk(clk), .rst_n(rst_n), .slot_addr(slot_addr), .slot_data(slot_data),
            .slot_mask(pending), .key(ld_key[w]), .match(ld_match[w]), .hit(ld_hit[w]),
            .data(ld_data[w]));
    end

    assign ld_hit_lo  = ld_hit[0];
    assign ld_data_lo = ld_data[0];
    assign ld_hit_hi  = ld_hit[1];
    assign ld_data_hi = ld_data[1];

    sq_lookup #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .UNIQUE(1'b1)) u_peer_cmp (
        .clk(clk), .rst_n(rst_n), .slot_addr(slot_addr), .slot_data(slot_data),
        .slot_mask(pending), .key(peer_addr), .match(peer_match), .hit(peer_hit),
        .data(peer_data));

    sq_drain u_drain (
        .clk(clk), .rst_n(rst_n), .arb_idle(arb_idle), .have_entry(have_entry),
        .head_live(live[head]), .mem_done(mem_done), .busy(busy), .pop(pop));

    assign mem_req  = busy;
    assign mem_addr = slot_addr[head];
    assign mem_data = slot_data[head];

    // Control state: live bits, pointers and occupancy; kills before writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live  <= '0;
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (peer_st_valid && kill_hit) begin
                live <= live & ~kill_match;
            end
            if (pop) begin
                live[head] <= 1'b0;
                head       <= head + 1'b1;
            end
            if (coalesce) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (st_match[i]) live[i] <= 1'b1;
                end
            end
            if (push) begin
                live[tail] <= 1'b1;
                tail       <= tail + 1'b1;
            end
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    // Payload storage: written on push and on coalesce, never reset.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (coalesce && st_match[i]) slot_data[i] <= st_data;
        end
        if (push) begin
            slot_addr[tail] <= st_addr;
            slot_data[tail] <= st_data;
        end
    end

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    assert_stall_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_stall |-> (count == CNT_W'(DEPTH)));
    assert_hold_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_done) |=> (mem_req && $stable(mem_addr) && $stable(mem_data)));
    assert_coalesce_no_grow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (coalesce && !pop) |=> $stable(count));
endmodule

// File: tb/store_queue_bench.sv
// Bench for store_queue: directed phases with lookup sweeps over a
// 16-word window and a modelled arbiter/memory that logs every write.
module store_queue_bench;
    localparam int AW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_valid = 1'b0;
    logic [AW-1:0] st_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic          st_stall;
    logic [AW-1:0] ld_addr_lo = '0, ld_addr_hi = '0, peer_addr = '0, peer_st_addr = '0;
    logic          ld_hit_lo, ld_hit_hi, peer_hit;
    logic [DW-1:0] ld_data_lo, ld_data_hi, peer_data;
    logic          peer_st_valid = 1'b0;
    logic          arb_idle = 1'b0;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data;
    logic          mem_done = 1'b0;

    int n_checks = 0;
    int n_err = 0;
    bit resp_en = 1'b0;
    int lat = 0;
    bit prev_req = 1'b0;
    int req_rises = 0;
    int wr_n = 0;
    logic [AW-1:0] wr_addr [0:31];
    logic [DW-1:0] wr_data [0:31];
    bit            exp_has [0:15];
    logic [DW-1:0] exp_val [0:15];

    always #4 clk = ~clk;

    store_queue #(.DEPTH(4), .ADDR_W(AW), .DATA_W(DW)) u_store_queue (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_stall(st_stall),
        .ld_addr_lo(ld_addr_lo), .ld_hit_lo(ld_hit_lo), .ld_data_lo(ld_data_lo),
        .ld_addr_hi(ld_addr_hi), .ld_hit_hi(ld_hit_hi), .ld_data_hi(ld_data_hi),
        .peer_addr(peer_addr), .peer_hit(peer_hit), .peer_data(peer_data),
        .peer_st_valid(peer_st_valid), .peer_st_addr(peer_st_addr),
        .arb_idle(arb_idle), .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_done(mem_done));

    // Memory model: completes a request after two sampled cycles, logs it.
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_done = 1'b0;
            lat = 0;
            prev_req = 1'b0;
        end else begin
            if (mem_req && !prev_req) req_rises++;
            prev_req = mem_req;
            if (mem_done) begin
                mem_done = 1'b0;
            end else if (mem_req && resp_en) begin
                lat++;
                if (lat >= 2) begin
                    mem_done = 1'b1;
                    lat = 0;
                    wr_addr[wr_n] = mem_addr;
                    wr_data[wr_n] = mem_data;
                    wr_n++;
                end
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic store(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_data = d;
        #1 check(tag, 32'(st_stall), 32'd0);
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    task automatic peer_store(input logic [AW-1:0] a);
        @(negedge clk);
        peer_st_valid = 1'b1; peer_st_addr = a;
        @(negedge clk);
        peer_st_valid = 1'b0;
    endtask

    // Lookup sweep over addresses 0..15 on all three ports; state must be frozen.
    task automatic sweep(input string tag);
        for (int a = 0; a < 16; a++) begin
            ld_addr_lo = AW'(a); ld_addr_hi = AW'(a ^ 1); peer_addr = AW'(a);
            #1;
            check({tag, " R7 lo hit"}, 32'(ld_hit_lo), 32'(exp_has[a]));
            check({tag, " R7 hi hit"}, 32'(ld_hit_hi), 32'(exp_has[a ^ 1]));
            check({tag, " R8 peer hit"}, 32'(peer_hit), 32'(exp_has[a]));
            if (exp_has[a]) begin
                check({tag, " R7 lo data"}, 32'(ld_data_lo), 32'(exp_val[a]));
                check({tag, " R8 peer data"}, 32'(peer_data), 32'(exp_val[a]));
            end
            if (exp_has[a ^ 1]) check({tag, " R7 hi data"}, 32'(ld_data_hi), 32'(exp_val[a ^ 1]));
        end
    endtask

    task automatic drain(input int target);
        arb_idle = 1'b1; resp_en = 1'b1;
        for (int c = 0; c < 300 && wr_n < target; c++) @(negedge clk);
        repeat (12) @(negedge clk);
        arb_idle = 1'b0;
        check("R4 write count after drain", 32'(wr_n), 32'(target));
        check("R3 no request left after drain", 32'(mem_req), 32'd0);
    endtask

    task automatic logged(input int idx, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input string tag);
        check({tag, " addr"}, 32'(wr_addr[idx]), 32'(a));
        check({tag, " data"}, 32'(wr_data[idx]), 32'(d));
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int base, r0;
        for (int a = 0; a < 16; a++) begin exp_has[a] = 1'b0; exp_val[a] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1: reset state
        check("R1 mem_req after reset", 32'(mem_req), 32'd0);
        check("R1 st_stall after reset", 32'(st_stall), 32'd0);
        sweep("R1 empty");

        // R7: a store is not visible before its accepting edge, visible after
        @(negedge clk);
        st_valid = 1'b1; st_addr = 8'd1; st_data = 16'h1001; ld_addr_lo = 8'd1;
        #1 check("R7 not visible before edge", 32'(ld_hit_lo), 32'd0);
        check("R2 first store no stall", 32'(st_stall), 32'd0);
        @(negedge clk);
        st_valid = 1'b0;
        #1 check("R7 visible after edge", 32'(ld_hit_lo), 32'd1);
        check("R7 data after edge", 32'(ld_data_lo), 32'h1001);
        exp_has[1] = 1; exp_val[1] = 16'h1001;
        store(8'd2, 16'h2002, "R2 store 2"); exp_has[2] = 1; exp_val[2] = 16'h2002;
        store(8'd3, 16'h3003, "R2 store 3"); exp_has[3] = 1; exp_val[3] = 16'h3003;
        store(8'd4, 16'h4004, "R2 store 4"); exp_has[4] = 1; exp_val[4] = 16'h4004;
        sweep("full");
        // R3: no request while arbiter busy
        for (int c = 0; c < 3; c++) begin
            @(negedge clk); #1 check("R3 no request while arbiter busy", 32'(mem_req), 32'd0);
        end

        // R6: coalesce into full queue without stall
        store(8'd2, 16'h2222, "R6 coalesce when full"); exp_val[2] = 16'h2222;
        sweep("coalesced");

        // R5: full-queue stall until one write completes
        @(negedge clk);
        st_valid = 1'b1; st_addr = 8'd5; st_data = 16'h5005;
        #1 check("R5 stall when full", 32'(st_stall), 32'd1);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk); #1 check("R5 stall held", 32'(st_stall), 32'd1);
        end
        arb_idle = 1'b1; resp_en = 1'b1;
        for (int c = 0; c < 50; c++) begin
            @(negedge clk); #1;
            if (!st_stall) break;
        end
        check("R5 stall released", 32'(st_stall), 32'd0);
        check("R5 released after exactly one write", 32'(wr_n), 32'd1);
        @(negedge clk);
        st_valid = 1'b0;
        drain(5);
        logged(0, 8'd1, 16'h1001, "R4 order 0");
        logged(1, 8'd2, 16'h2222, "R6 single newest write");
        logged(2, 8'd3, 16'h3003, "R4 order 2");
        logged(3, 8'd4, 16'h4004, "R4 order 3");
        logged(4, 8'd5, 16'h5005, "R5 stalled store written");
        for (int a = 0; a < 16; a++) exp_has[a] = 1'b0;
        sweep("drained");

        // R9: peer kill of a pending entry
        store(8'd8, 16'h8008, "R2 store 8");
        store(8'd9, 16'h9009, "R2 store 9");
        store(8'd10, 16'hA00A, "R2 store 10");
        peer_store(8'd9);
        exp_has[8] = 1; exp_val[8] = 16'h8008;
        exp_has[10] = 1; exp_val[10] = 16'hA00A;
        sweep("R9 killed");
        base = wr_n; r0 = req_rises;
        drain(base + 2);
        check("R9 dead entry skipped without request", 32'(req_rises - r0), 32'd2);
        logged(base, 8'd8, 16'h8008, "R9 write 8");
        logged(base + 1, 8'd10, 16'hA00A, "R9 write 10");
        for (int a = 0; a < 16; a++) exp_has[a] = 1'b0;

        // R10: kill of an in-flight entry
        resp_en = 1'b0; arb_idle = 1'b1;
        store(8'd11, 16'hB0B0, "R2 store 11");
        for (int c = 0; c < 20 && !mem_req; c++) @(negedge clk);
        arb_idle = 1'b0;
        ld_addr_lo = 8'd11;
        #1 check("R10 in-flight not forwarded", 32'(ld_hit_lo), 32'd0);
        peer_store(8'd11);
        store(8'd11, 16'hB1B1, "R10 new entry no stall");
        ld_addr_lo = 8'd11; peer_addr = 8'd11;
        #1 check("R10 new entry hit", 32'(ld_hit_lo), 32'd1);
        check("R10 new entry data", 32'(ld_data_lo), 32'hB1B1);
        check("R10 write still held addr", 32'(mem_addr), 32'd11);
        check("R10 write still held data", 32'(mem_data), 32'hB0B0);
        base = wr_n;
        drain(base + 2);
        logged(base, 8'd11, 16'hB0B0, "R10 killed write completes");
        logged(base + 1, 8'd11, 16'hB1B1, "R10 newer write follows");

        // R11: local store beats simultaneous peer store
        store(8'd12, 16'hC001, "R2 store 12");
        @(negedge clk);
        st_valid = 1'b1; st_addr = 8'd12; st_data = 16'hC002;
        peer_st_valid = 1'b1; peer_st_addr = 8'd12;
        @(negedge clk);
        st_valid = 1'b1; st_addr = 8'd13; st_data = 16'hD013;
        peer_st_valid = 1'b1; peer_st_addr = 8'd13;
        @(negedge clk);
        st_valid = 1'b0; peer_st_valid = 1'b0;
        exp_has[12] = 1; exp_val[12] = 16'hC002;
        exp_has[13] = 1; exp_val[13] = 16'hD013;
        sweep("R11 local wins");
        base = wr_n;
        drain(base + 2);
        logged(base, 8'd12, 16'hC002, "R11 write 12");
        logged(base + 1, 8'd13, 16'hD013, "R11 write 13");

        finish_run();
    end
endmodule